// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is a 16-bit timer that produces a repeating pulse-width-modulated waveform, or a single pulse, on one output pin. Software programs a period value and a duty value through a small byte-wide write port. The counter starts from zero and counts selected ticks up to the period value, then wraps. The output is at its active level while the count is below the duty value and at its inactive level for the rest of the period. The period value is an inclusive count limit, so one period lasts period+1 ticks.

The period and duty values are double-buffered. While the timer runs, writes reach only the data registers. The working copies take the new values on the next period match, so a waveform is never cut mid-period. Each period match raises an interrupt request that stays set until acknowledged. In single-pulse mode the hardware drops the enable bit after one full period. A three-bit selector sets the tick rate. The choices are the system clock, the system clock divided by a power of two, or an event input from a neighbouring timer.

Top module: `pulse_gen_timer`

## Requirements
- R1: After reset the enable, mode, clock-select and polarity fields and both data registers are zero, `irq` is 0 and `pulseOut` is 0.
- R2: Write addresses are 0 control (bit7 enable, bits5:4 mode, bit0 counter-clear strobe), 1 config (bits2:0 tick select, bit4 polarity), 2/3 period low/high byte, 4/5 duty low/high byte. While enabled, the counter goes 0,1,..,P and then back to 0, one step per tick, so the period is P+1 ticks.
- R3: With polarity 0, `pulseOut` is 1 while the count is below the duty value D and 0 otherwise. D=0 gives an output that is never active. Any D greater than P gives an output that is active for the whole period.
- R4: Polarity 1 inverts the level in both phases. While the timer is disabled, `pulseOut` rests at the idle level, which equals the polarity bit.
- R5: While the timer is disabled, the working copies follow the data registers. While it runs, a new period or duty value takes effect only after the next period match.
- R6: Each period match sets `irq` on the following edge. A one-cycle `intAck` pulse clears it. If a match and an acknowledge fall in the same cycle, the set wins.
- R7: With mode 01, the timer clears its own enable bit at the end of the first period. Exactly one pulse of D active ticks appears, and the output then stays idle. Modes 00, 10 and 11 repeat.
- R8: The tick select codes are 000 = clock/2, 001 = /4, 010 = /8, 011 = /32, 100 = /128, 101 = /512, 110 = every clock and 111 = external tick. The divider restarts from zero each time the timer is enabled.
- R9: With select 111, the counter advances once for each clock cycle in which `extTick` is 1, and holds while it is 0.
- R10: Writing the control byte with bit0 set forces the count to 0 on that edge. A disabled timer also holds the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| extTick | input | 1 | Match event from another timer |
| intAck | input | 1 | Interrupt acknowledge pulse |
| pulseOut | output | 1 | Pulse / PWM output |
| irq | output | 1 | Interrupt request (period match flag) |

## Verification
A table of period, duty and polarity settings drives the timer on the every-clock tick. Each setting is checked by counting active cycles over two periods. The settings include a mid-range duty, zero duty, duty equal to period+1 and well above it, a period of zero, and a value above 255. Together they separate a below-compare from a below-or-equal compare, and expose a lost high byte or an inverted polarity. Directed runs cover the rest:
- A duty change written mid-period shows whether the buffer reloads early.
- Single-pulse mode shows whether the enable is cleared after exactly one period.
- Held and pulsed external ticks show whether the counter advances on the wrong condition.
- The divide-by-two select and the clear strobe each check one selector code and the counter clear.

// File: rtl/ppg_pkg.sv
package ppg_pkg;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_CFG  = 3'd1;
  localparam logic [2:0] ADDR_PLO  = 3'd2;
  localparam logic [2:0] ADDR_PHI  = 3'd3;
  localparam logic [2:0] ADDR_DLO  = 3'd4;
  localparam logic [2:0] ADDR_DHI  = 3'd5;

  localparam logic [1:0] MODE_ONESHOT = 2'b01;

  localparam logic [2:0] SEL_DIRECT = 3'd6;
  localparam logic [2:0] SEL_EXT    = 3'd7;

  // strobes from control to datapath
  typedef struct packed {
    logic run;       // timer enabled
    logic tick;      // advance counter this cycle
    logic cntClr;    // force count to zero
    logic loadBufs;  // copy data registers into working buffers
  } dpStrobe_t;

endpackage

// File: rtl/ppg_prescaler.sv
module ppg_prescaler #(
  parameter int DIV_W = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic [2:0] sel,
  input  logic       extTick,
  output logic       tick
);
  import ppg_pkg::*;

  localparam int NTAPS = 6;

  function automatic int tapExp(input int i);
    case (i)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      3:       return 5;
      4:       return 7;
      default: return 9;
    endcase
  endfunction

  logic [DIV_W-1:0] divCnt;
  logic [NTAPS-1:0] taps;
  logic             rawTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      divCnt <= '0;
    else if (!run)  divCnt <= '0;
    else            divCnt <= divCnt + 1'b1;
  end

  for (genvar g = 0; g < NTAPS; g++) begin : gTap
    localparam int E = tapExp(g);
    assign taps[g] = &divCnt[E-1:0];
  end

  always_comb begin
    if (sel == SEL_DIRECT)     rawTick = 1'b1;
    else if (sel == SEL_EXT)   rawTick = extTick;
    else                       rawTick = taps[sel];
  end

  assign tick = run & rawTick;

  // R8: divide-by-two tick never fires on two consecutive cycles
  p_div2_alt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (run && sel == 3'd0 && tick) |=> !(tick && sel == 3'd0));

  // R8: direct select ticks every cycle while running
  p_direct_r8: assert property (@(posedge clk) disable iff (!rstN)
    (run && sel == SEL_DIRECT) |-> tick);

endmodule

// File: rtl/ppg_ctrl.sv
module ppg_ctrl #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 9
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [2:0]           wrAddr,
  input  logic [7:0]           wrData,
  input  logic                 extTick,
  input  logic                 intAck,
  input  logic                 aMatch,
  output ppg_pkg::dpStrobe_t   strobes,
  output logic [CNT_W-1:0]     regA,
  output logic [CNT_W-1:0]     regB,
  output logic                 pol,
  output logic                 irq
);
  import ppg_pkg::*;

  localparam int HI_W = CNT_W - 8;

  logic       en;
  logic [1:0] mode;
  logic [2:0] clkSel;
  logic       irqFlag;
  logic       ctrlWr;
  logic       clrCmd;
  logic       tick;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);
  assign clrCmd = ctrlWr && wrData[0];

  ppg_prescaler #(.DIV_W(DIV_W)) u_pres (
    .clk     (clk),
    .rstN    (rstN),
    .run     (en),
    .sel     (clkSel),
    .extTick (extTick),
    .tick    (tick)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en     <= 1'b0;
      mode   <= 2'b00;
      clkSel <= 3'd0;
      pol    <= 1'b0;
      regA   <= '0;
      regB   <= '0;
    end else begin
      if (aMatch && mode == MODE_ONESHOT) en <= 1'b0;
      if (wrEn) begin
        case (wrAddr)
          ADDR_CTRL: begin
            en   <= wrData[7];
            mode <= wrData[5:4];
          end
          ADDR_CFG: begin
            clkSel <= wrData[2:0];
            pol    <= wrData[4];
          end
          ADDR_PLO: regA[7:0]       <= wrData;
          ADDR_PHI: regA[CNT_W-1:8] <= wrData[HI_W-1:0];
          ADDR_DLO: regB[7:0]       <= wrData;
          ADDR_DHI: regB[CNT_W-1:8] <= wrData[HI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        irqFlag <= 1'b0;
    else if (aMatch)  irqFlag <= 1'b1;
    else if (intAck)  irqFlag <= 1'b0;
  end

  assign irq = irqFlag;

  always_comb begin
    strobes.run      = en;
    strobes.tick     = tick;
    strobes.cntClr   = !en || clrCmd;
    strobes.loadBufs = !en;
  end

  // R6: a match always leaves the flag set
  p_irq_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    aMatch |=> irq);

  // R6: acknowledge without a match clears the flag
  p_irq_ack_r6: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !aMatch) |=> !irq);

  // R7: single-pulse mode drops enable after its period match
  p_oneshot_r7: assert property (@(posedge clk) disable iff (!rstN)
    (aMatch && mode == MODE_ONESHOT && !ctrlWr) |=> !en);

endmodule

// File: rtl/ppg_datapath.sv
module ppg_datapath #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ppg_pkg::dpStrobe_t strobes,
  input  logic [CNT_W-1:0]   regA,
  input  logic [CNT_W-1:0]   regB,
  input  logic               pol,
  output logic               aMatch,
  output logic               pulseOut
);
  import ppg_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] bufA;
  logic [CNT_W-1:0] bufB;
  logic             active;

  assign aMatch = strobes.tick && !strobes.cntClr && (cnt == bufA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         cnt <= '0;
    else if (strobes.cntClr || aMatch) cnt <= '0;
    else if (strobes.tick)             cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufA <= '0;
      bufB <= '0;
    end else if (strobes.loadBufs || aMatch) begin
      bufA <= regA;
      bufB <= regB;
    end
  end

  assign active   = (cnt < bufB);
  assign pulseOut = strobes.run ? (active ^ pol) : pol;

  // R2: count never passes the working period value
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= bufA);

  // R2: period match wraps the counter
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    aMatch |=> (cnt == '0));

  // R5: working copies hold while running between matches
  p_buf_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.run && !aMatch) |=> ($stable(bufA) && $stable(bufB)));

  // R10: clear strobe zeroes the count
  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntClr |=> (cnt == '0));

endmodule

// File: rtl/pulse_gen_timer.sv
module pulse_gen_timer #(
  parameter int CNT_W = 16,
  parameter int DIV_W = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       extTick,
  input  logic       intAck,
  output logic       pulseOut,
  output logic       irq
);
  import ppg_pkg::*;

  dpStrobe_t        strobes;
  logic [CNT_W-1:0] regA;
  logic [CNT_W-1:0] regB;
  logic             pol;
  logic             aMatch;

  ppg_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .extTick (extTick),
    .intAck  (intAck),
    .aMatch  (aMatch),
    .strobes (strobes),
    .regA    (regA),
    .regB    (regB),
    .pol     (pol),
    .irq     (irq)
  );

  ppg_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .regA     (regA),
    .regB     (regB),
    .pol      (pol),
    .aMatch   (aMatch),
    .pulseOut (pulseOut)
  );

  // R4: disabled timer rests at the polarity level
  p_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.run |-> (pulseOut == pol));

endmodule

// File: tb/sim_pulse_gen_timer.sv
`timescale 1ns/1ps
module sim_pulse_gen_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = 3'd0;
  logic [7:0] wrData = 8'd0;
  logic       extTick = 1'b0;
  logic       intAck = 1'b0;
  logic       pulseOut;
  logic       irq;

  int nChk = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  pulse_gen_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extTick(extTick), .intAck(intAck), .pulseOut(pulseOut), .irq(irq)
  );

  // {period, duty, polarity}
  localparam int NV = 8;
  localparam logic [32:0] VEC [NV] = '{
    {16'd9,   16'd4,   1'b0},
    {16'd9,   16'd0,   1'b0},
    {16'd9,   16'd12,  1'b0},
    {16'd9,   16'd10,  1'b0},
    {16'd0,   16'd1,   1'b0},
    {16'd7,   16'd3,   1'b1},
    {16'd300, 16'd100, 1'b1},
    {16'd5,   16'd5,   1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; commits on the next posedge, returns at next negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ack();
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic tickExt();
    extTick = 1'b1;
    @(negedge clk);
    extTick = 1'b0;
  endtask

  // samples n cycles starting now, counts cycles at active level
  task automatic countActive(input int n, input logic p, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      if (pulseOut == ~p) c++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] b,
                       input logic p, input logic [2:0] sel);
    wr(3'd0, 8'h00);
    wr(3'd1, {3'b000, p, 1'b0, sel});
    wr(3'd2, a[7:0]);
    wr(3'd3, a[15:8]);
    wr(3'd4, b[7:0]);
    wr(3'd5, b[15:8]);
    ack();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    int c;
    int expc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(pulseOut == 1'b0, "R1 pulseOut after reset", int'(pulseOut), 0);
    chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);

    // table walk: R2 R3 R4 R6
    for (int v = 0; v < NV; v++) begin
      logic [15:0] a;
      logic [15:0] b;
      logic p;
      a = VEC[v][32:17];
      b = VEC[v][16:1];
      p = VEC[v][0];
      setup(a, b, p, 3'd6);
      chk(pulseOut == p, "R4 idle level while disabled", int'(pulseOut), int'(p));
      chk(irq == 1'b0, "R6 irq cleared by ack", int'(irq), 0);
      wr(3'd0, 8'h80);
      countActive(2 * (int'(a) + 1), p, c);
      expc = 2 * ((int'(b) < int'(a) + 1) ? int'(b) : int'(a) + 1);
      chk(c == expc, "R2/R3 active cycles over two periods", c, expc);
      chk(irq == 1'b1, "R6 irq after period match", int'(irq), 1);
    end

    // R5: duty change mid-period takes effect next period
    setup(16'd5, 16'd2, 1'b0, 3'd6);
    wr(3'd0, 8'h80);
    countActive(2, 1'b0, c);
    wr(3'd4, 8'd4);
    countActive(3, 1'b0, c);
    chk(c == 0, "R5 old duty kept to end of period", c, 0);
    countActive(6, 1'b0, c);
    chk(c == 4, "R5 new duty after match", c, 4);

    // R7: single pulse
    setup(16'd3, 16'd2, 1'b0, 3'd6);
    wr(3'd0, 8'h90);
    countActive(20, 1'b0, c);
    chk(c == 2, "R7 one pulse only", c, 2);
    chk(irq == 1'b1, "R7 irq from single period", int'(irq), 1);
    chk(pulseOut == 1'b0, "R7 idle after pulse", int'(pulseOut), 0);

    // R8: divide by two, period 2 ticks = 4 clocks
    setup(16'd1, 16'd1, 1'b0, 3'd0);
    wr(3'd0, 8'h80);
    countActive(8, 1'b0, c);
    chk(c == 4, "R8 clock/2 active cycles", c, 4);
    countActive(8, 1'b0, c);
    chk(c == 4, "R8 clock/2 second window", c, 4);

    // R9: external tick
    setup(16'd2, 16'd1, 1'b0, 3'd7);
    wr(3'd0, 8'h80);
    chk(pulseOut == 1'b1, "R9 count 0 active", int'(pulseOut), 1);
    repeat (3) @(negedge clk);
    chk(pulseOut == 1'b1, "R9 no tick holds count", int'(pulseOut), 1);
    tickExt();
    chk(pulseOut == 1'b0, "R9 one tick advances", int'(pulseOut), 0);
    chk(irq == 1'b0, "R9 no match yet", int'(irq), 0);
    tickExt();
    tickExt();
    chk(pulseOut == 1'b1, "R9 wrap after three ticks", int'(pulseOut), 1);
    chk(irq == 1'b1, "R9 match after three ticks", int'(irq), 1);

    // R10: clear strobe
    setup(16'd9, 16'd5, 1'b0, 3'd6);
    wr(3'd0, 8'h80);
    countActive(3, 1'b0, c);
    wr(3'd0, 8'h81);
    countActive(5, 1'b0, c);
    chk(c == 5, "R10 count restarted by clear", c, 5);
    countActive(5, 1'b0, c);
    chk(c == 0, "R10 inactive tail after clear", c, 0);

    // R6: irq holds without ack, clears with ack while disabled
    wr(3'd0, 8'h00);
    chk(irq == 1'b1, "R6 irq held until ack", int'(irq), 1);
    ack();
    chk(irq == 1'b0, "R6 ack clears irq", int'(irq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule